// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters for a host. While idle it watches the line for a fall from high to low. It takes such a fall as a possible start bit and looks at the line again half a bit time later. If the line is low at that second look, the receiver samples the data bits one by one at mid-bit, then the optional parity bit, then the stop bit. It then writes the finished character into a one-entry receive buffer and raises a ready flag.

All timing comes from a receive tick enable, which pulses at 1, 16 or 64 times the bit rate. Mode inputs select the tick ratio, the character length and the parity. Three sticky error flags record parity, framing and overrun errors, and a clear pulse resets all three at once. The host takes a character by pulsing a read strobe.

Top module: `serial_rx_oversamp`

## Requirements
- R1: After reset, `rx_data` is zero and `rx_ready`, `err_parity`, `err_frame` and `err_overrun` are all low.
- R2: All sampling happens on clock edges where `tick` is high. In 16x and 64x modes the receiver is idle and sees the line high on one tick, then low on a later tick. It then samples the line again on the 8th or 32nd tick after that (half a bit). If the line is low there, the start is accepted.
- R3: If the line is high at the half-bit re-check, the start is rejected, the receiver returns to idle and no character is delivered.
- R4: Data bits are sampled one bit time (16 or 64 ticks, or 1 tick in 1x mode) apart, least-significant bit first. `len_sel` gives the length: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. The character appears right-aligned in `rx_data` with the unused upper bits zero.
- R5: The stop bit is sampled one bit time after the last data or parity bit. `rx_ready` rises on the clock edge after that sample. It falls on the edge after a cycle in which `rd_pulse` is high. If a new character completes in that same cycle, the new character wins and `rx_ready` stays high.
- R6: When `par_en` is 1, one parity bit follows the data bits. Set `par_even`=1 to check for an even count of ones over the data bits plus the parity bit, or `par_even`=0 for an odd count. A mismatch sets `err_parity`. When `par_en` is 0, no parity bit is expected and `err_parity` is never set.
- R7: A stop-bit sample that reads low sets `err_frame`. The character is still delivered and `rx_ready` is still raised.
- R8: If a character completes while `rx_ready` is high and `rd_pulse` is low, `err_overrun` is set. The new character replaces the old one in `rx_data`.
- R9: The error flags are sticky. A cycle with `err_clr` high clears all three on the next edge, unless an error is detected on that same edge.
- R10: While `rx_en` is 0, no character is received and any frame in progress is dropped. After `rx_en` returns to 1, the line must be sampled high once before a start can be detected.
- R11: In 1x mode there is no half-bit re-check. The tick on which the line is first seen low counts as the start bit, and each following tick samples one bit.
- R12: `rate_sel` chooses the tick ratio: 0 selects 1x, 1 selects 16x, and 2 or 3 selects 64x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input line, high when idle |
| tick | input | 1 | Receive tick enable (1x, 16x or 64x the bit rate) |
| rx_en | input | 1 | Receiver enable |
| rate_sel | input | 2 | Tick ratio select |
| len_sel | input | 2 | Character length select (5 to 8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| err_clr | input | 1 | Clears all three error flags |
| rd_pulse | input | 1 | Host read strobe, clears `rx_ready` |
| rx_data | output | DW | Last received character, right-aligned |
| rx_ready | output | 1 | Unread character in the buffer |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The bench builds the block with its default parameters: an 8-bit character limit and a 6-bit tick counter. This counter is wide enough for the 64x bit time, so every tick ratio, every character length from 5 to 8 bits and both parity senses can be reached from the mode pins. The tick pulses once every three clocks, so the bench also shows that clocks without a tick do not advance the receiver. A short low glitch, a low stop bit, two characters sent back to back without a read, and a frame sent while the receiver is disabled cover the rejection and error paths.

// File: rtl/serial_rx_oversamp.sv
module serial_rx_oversamp #(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          tick,
  input  logic          rx_en,
  input  logic [1:0]    rate_sel,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          err_clr,
  input  logic          rd_pulse,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          err_parity,
  output logic          err_frame,
  output logic          err_overrun
);
  localparam int IW = $clog2(DW);
  localparam int LW = IW + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;
  logic          prev_hi;
  logic          par_acc;
  logic [CW:0]   div;

  always_comb begin
    case (rate_sel)
      2'd0:    div = (CW+1)'(1);
      2'd1:    div = (CW+1)'(16);
      default: div = (CW+1)'(64);
    endcase
  end

  wire [CW:0]   half_m1 = (div >> 1) - (CW+1)'(1);
  wire          at_half = ({1'b0, cnt} == half_m1);
  wire          at_full = ({1'b0, cnt} == div - (CW+1)'(1));
  wire [LW-1:0] nbits   = LW'(DW - 3) + LW'(len_sel);
  wire          last_db = ({1'b0, idx} == nbits - LW'(1));
  wire          deliver = rx_en && tick && (st == S_STOP) && at_full;
  wire          perr    = par_en && (par_acc == par_even);
  wire          ferr    = !rx_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      prev_hi <= 1'b0;
      par_acc <= 1'b0;
    end else if (!rx_en) begin
      st      <= S_IDLE;
      cnt     <= '0;
      prev_hi <= 1'b0;
    end else if (tick) begin
      case (st)
        S_IDLE: begin
          prev_hi <= rx_line;
          cnt     <= '0;
          idx     <= '0;
          sh      <= '0;
          par_acc <= 1'b0;
          if (prev_hi && !rx_line)
            st <= (div == (CW+1)'(1)) ? S_DATA : S_START;
        end
        S_START: begin
          if (at_half) begin
            cnt <= '0;
            if (rx_line) begin
              st      <= S_IDLE;
              prev_hi <= 1'b1;
            end else begin
              st <= S_DATA;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_DATA: begin
          if (at_full) begin
            cnt     <= '0;
            sh[idx] <= rx_line;
            par_acc <= par_acc ^ rx_line;
            if (last_db) begin
              idx <= '0;
              st  <= par_en ? S_PAR : S_STOP;
            end else begin
              idx <= idx + IW'(1);
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_PAR: begin
          if (at_full) begin
            cnt     <= '0;
            par_acc <= par_acc ^ rx_line;
            st      <= S_STOP;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_STOP: begin
          if (at_full) begin
            cnt     <= '0;
            st      <= S_IDLE;
            prev_hi <= rx_line;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (deliver) begin
        rx_data  <= sh;
        rx_ready <= 1'b1;
      end else if (rd_pulse) begin
        rx_ready <= 1'b0;
      end
      err_parity  <= (err_parity  && !err_clr) || (deliver && perr);
      err_frame   <= (err_frame   && !err_clr) || (deliver && ferr);
      err_overrun <= (err_overrun && !err_clr) || (deliver && rx_ready && !rd_pulse);
    end
  end

  p_ready_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && rd_pulse && !deliver) |=> !rx_ready);

  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && rx_ready && !rd_pulse) |=> err_overrun);

  p_frame_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !err_clr) |=> err_frame);

  p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !deliver) |=> (!err_parity && !err_frame && !err_overrun));

  p_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == S_IDLE));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> ((rx_data >> $past(nbits)) == '0));

  p_no_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_en && !err_parity) |=> !err_parity);
endmodule

// File: tb/test_serial_rx_oversamp.sv
module test_serial_rx_oversamp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick = 1'b0;
  logic       rx_en = 1'b0;
  logic [1:0] rate_sel = 2'd1;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       err_clr = 1'b0;
  logic       rd_pulse = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_frame, err_overrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tdiv = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  serial_rx_oversamp i_serial_rx_oversamp (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick(tick), .rx_en(rx_en),
    .rate_sel(rate_sel), .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
    .err_clr(err_clr), .rd_pulse(rd_pulse), .rx_data(rx_data), .rx_ready(rx_ready),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    tick = (tdiv == 0);
  end

  // behavioural reference model
  int   m_phase = 0;
  int   m_wait = 0;
  bit   m_prev = 1'b0;
  bit   m_bits[$];
  logic [7:0] e_data = 8'h00;
  bit   e_rdy = 1'b0, e_pe = 1'b0, e_fe = 1'b0, e_oe = 1'b0;
  bit   m_del, m_npe, m_nfe, m_noe;
  logic [7:0] m_nd;
  int   m_dv, m_len, m_need, m_ones;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_prev = 1'b0; m_bits.delete();
      e_data = 8'h00; e_rdy = 0; e_pe = 0; e_fe = 0; e_oe = 0;
    end else begin
      m_del = 0; m_npe = 0; m_nfe = 0; m_nd = 8'h00;
      m_dv = (rate_sel == 2'd0) ? 1 : (rate_sel == 2'd1) ? 16 : 64;
      m_len = 5 + int'(len_sel);
      m_need = m_len + (par_en ? 1 : 0) + 1;
      if (!rx_en) begin
        m_phase = 0; m_prev = 1'b0; m_bits.delete();
      end else if (tick) begin
        if (m_phase == 0) begin
          if (m_prev && !rx_line) begin
            m_bits.delete();
            if (m_dv == 1) begin m_phase = 2; m_wait = 1; end
            else begin m_phase = 1; m_wait = m_dv / 2; end
          end
          m_prev = rx_line;
        end else begin
          m_wait--;
          if (m_wait == 0) begin
            if (m_phase == 1) begin
              if (rx_line) begin m_phase = 0; m_prev = 1'b1; end
              else begin m_phase = 2; m_wait = m_dv; end
            end else begin
              m_bits.push_back(rx_line);
              if (m_bits.size() == m_need) begin
                m_ones = 0;
                for (int i = 0; i < m_len; i++) begin
                  m_nd[i] = m_bits[i];
                  m_ones += int'(m_bits[i]);
                end
                if (par_en) m_ones += int'(m_bits[m_len]);
                m_npe = par_en && ((m_ones % 2) != (par_even ? 0 : 1));
                m_nfe = !m_bits[m_need-1];
                m_del = 1;
                m_phase = 0;
                m_prev = rx_line;
              end else begin
                m_wait = m_dv;
              end
            end
          end
        end
      end
      m_noe = m_del && e_rdy && !rd_pulse;
      e_pe = (e_pe && !err_clr) || (m_del && m_npe);
      e_fe = (e_fe && !err_clr) || (m_del && m_nfe);
      e_oe = (e_oe && !err_clr) || m_noe;
      if (m_del) begin e_data = m_nd; e_rdy = 1; end
      else if (rd_pulse) e_rdy = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 model rx_data", rx_data, e_data);
      chk("R5 model rx_ready", {7'd0, rx_ready}, {7'd0, e_rdy});
      chk("R6 model err_parity", {7'd0, err_parity}, {7'd0, e_pe});
      chk("R7 model err_frame", {7'd0, err_frame}, {7'd0, e_fe});
      chk("R8 model err_overrun", {7'd0, err_overrun}, {7'd0, e_oe});
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL R5 watchdog actual=%0d cycles expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int cur_div();
    return (rate_sel == 2'd0) ? 1 : (rate_sel == 2'd1) ? 16 : 64;
  endfunction

  task automatic hold(input bit v, input int n);
    @(negedge clk);
    rx_line = v;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v);
    int dv;
    int len;
    bit p;
    dv = cur_div();
    len = 5 + int'(len_sel);
    p = 1'b0;
    hold(1'b0, dv);
    for (int i = 0; i < len; i++) begin
      hold(d[i], dv);
      p = p ^ d[i];
    end
    if (par_en) begin
      if (!par_even) p = ~p;
      if (bad_par) p = ~p;
      hold(p, dv);
    end
    hold(stop_v, dv);
    hold(1'b1, 4);
  endtask

  task automatic host_read();
    @(negedge clk) rd_pulse = 1'b1;
    @(negedge clk) rd_pulse = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset rx_data", rx_data, 8'h00);
    chk("R1 reset flags", {4'd0, rx_ready, err_parity, err_frame, err_overrun}, 8'h00);
    cmp_on = 1'b1;
    rst_n = 1'b1;
    rx_en = 1'b1;
    hold(1'b1, 4);

    send(8'hA5, 0, 1);
    @(negedge clk);
    chk("R2 R4 16x byte", rx_data, 8'hA5);
    chk("R5 ready after stop", {7'd0, rx_ready}, 8'd1);
    host_read();
    chk("R5 ready cleared by read", {7'd0, rx_ready}, 8'd0);

    len_sel = 2'd0;
    send(8'hF3, 0, 1);
    @(negedge clk);
    chk("R4 five bit right aligned", rx_data, 8'h13);
    host_read();
    len_sel = 2'd3;

    par_en = 1'b1; par_even = 1'b1;
    send(8'h3C, 0, 1);
    @(negedge clk);
    chk("R6 even parity good", {7'd0, err_parity}, 8'd0);
    host_read();
    send(8'h3C, 1, 1);
    @(negedge clk);
    chk("R6 even parity bad", {7'd0, err_parity}, 8'd1);
    chk("R6 data with parity", rx_data, 8'h3C);
    host_read();
    clear_err();
    chk("R9 clear parity flag", {7'd0, err_parity}, 8'd0);
    par_even = 1'b0;
    send(8'h07, 1, 1);
    @(negedge clk);
    chk("R6 odd parity bad", {7'd0, err_parity}, 8'd1);
    host_read();
    send(8'h07, 0, 1);
    @(negedge clk);
    chk("R6 flag sticky", {7'd0, err_parity}, 8'd1);
    host_read();
    clear_err();
    par_en = 1'b0;

    send(8'h5A, 0, 0);
    @(negedge clk);
    chk("R7 framing flag", {7'd0, err_frame}, 8'd1);
    chk("R7 data still delivered", rx_data, 8'h5A);
    chk("R7 ready still set", {7'd0, rx_ready}, 8'd1);
    host_read();
    clear_err();
    chk("R9 clear frame flag", {7'd0, err_frame}, 8'd0);

    send(8'h11, 0, 1);
    send(8'h22, 0, 1);
    @(negedge clk);
    chk("R8 overrun flag", {7'd0, err_overrun}, 8'd1);
    chk("R8 newer byte kept", rx_data, 8'h22);
    host_read();
    clear_err();
    chk("R9 clear overrun flag", {7'd0, err_overrun}, 8'd0);

    hold(1'b0, 3);
    hold(1'b1, 40);
    @(negedge clk);
    chk("R3 glitch rejected", {7'd0, rx_ready}, 8'd0);
    send(8'h66, 0, 1);
    @(negedge clk);
    chk("R3 frame after glitch", rx_data, 8'h66);
    host_read();

    rate_sel = 2'd2;
    hold(1'b1, 4);
    send(8'hC3, 0, 1);
    @(negedge clk);
    chk("R12 64x byte", rx_data, 8'hC3);
    host_read();
    rate_sel = 2'd0;
    hold(1'b1, 4);
    send(8'h81, 0, 1);
    @(negedge clk);
    chk("R11 1x byte", rx_data, 8'h81);
    host_read();
    rate_sel = 2'd1;
    hold(1'b1, 4);

    @(negedge clk) rx_en = 1'b0;
    send(8'h99, 0, 1);
    @(negedge clk);
    chk("R10 disabled no ready", {7'd0, rx_ready}, 8'd0);
    chk("R10 disabled data kept", rx_data, 8'h81);
    @(negedge clk) rx_en = 1'b1;
    hold(1'b1, 4);
    send(8'h42, 0, 1);
    @(negedge clk);
    chk("R10 enabled again", rx_data, 8'h42);
    host_read();

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule